// File: doc/BRIEF.md
# Memory Mailbox with Block CRC

This block gives a management master, which can only move 16 bits per register access, a way to fill a processor memory that is organised in 32-bit words. The master sets a word-aligned target pointer in two halves, stages a 32-bit word in two halves, and then writes a command to the control register. The command copies the staged word onto a synchronous memory write port at the pointer, and the pointer steps on to the next word. A long block therefore needs only the two data halves and one command per word.

Each committed word is also folded, byte by byte with the most significant byte first, into a CRC-16 accumulator. The master can read this accumulator back at the end of a block and compare it with its own figure to confirm the load. A separate control bit clears the accumulator before a new block. While a word is being folded in, the control register shows a busy flag. Control commands sent during that window are dropped.

Top module: `mbox_crc_loader`

## Requirements
- R1: After reset the memory write strobe is low, the CRC reads 0x0000, and every mapped register reads 0x0000.
- R2: The registers are mapped from a base of 0x200: control at +0, CRC at +1, pointer upper half at +2, pointer lower half at +3, staged data upper half at +4 and staged data lower half at +5. A read strobe returns data on `reg_rdata` one clock later. The data and control registers return what was last written. The pointer registers return the current pointer. Any other offset reads 0x0000.
- R3: A write to the lower pointer half always stores bits 1:0 as zero.
- R4: A control write with bit 15 (execute) and bit 14 (write) both set, while idle, raises `mem_we` for exactly one cycle on the next clock. `mem_addr` then holds the pointer and `mem_wdata` holds {upper data half, lower data half}.
- R5: Each commit advances the pointer by 4. A carry out of the lower half propagates into the upper half.
- R6: The CRC uses polynomial 0x1021 with initial value 0, no reflection and no final XOR. It is updated with the four bytes of every committed word, most significant byte first.
- R7: A control write with bit 12 set, while idle, clears the CRC to 0x0000. If the same write also commits a word, the clear takes effect first.
- R8: Control bit 8 reads 1 for the four cycles after a commit, one cycle per CRC byte. Control writes arriving during that window neither commit nor clear.
- R9: A control write with execute set but write clear produces no memory write, leaves the CRC unchanged and leaves the pointer unchanged.
- R10: The staged data halves may be rewritten while busy without changing the word already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 16 | Register offset for the access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid one cycle after `reg_rd` |
| mem_we | output | 1 | Memory write enable, one-cycle pulse per commit |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write word |

## Verification
A commit sampled at clock edge E0 drives `mem_we`, `mem_addr` and `mem_wdata` from E0 on. The pointer has advanced by E0. The CRC absorbs one byte at each of E1 to E4, so it is final after E4, and the busy flag is visible from E0 up to E4. The bench drives every access on a falling edge, so each strobe is sampled on the following rising edge. A register read is taken on the falling edge after its strobe. Commands are spaced four idle cycles after a commit unless a test deliberately hits the busy window. A scoreboard queues each expected memory write when the command is issued, and a monitor compares every `mem_we` pulse on the falling edge against that queue.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // register indices relative to the block base
  localparam int IDX_CTRL  = 0;
  localparam int IDX_CRC   = 1;
  localparam int IDX_PTR_H = 2;
  localparam int IDX_PTR_L = 3;
  localparam int IDX_DAT_H = 4;
  localparam int IDX_DAT_L = 5;

  // control bit positions
  localparam int BIT_EXEC  = 15;
  localparam int BIT_WRITE = 14;
  localparam int BIT_CLR   = 12;
  localparam int BIT_BUSY  = 8;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  // fold one byte into a non-reflected CRC-16
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int REG_AW = 16,
  parameter int DW     = 16,
  parameter int BASE   = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              advance,
  output logic [2*DW-1:0]   ptr,
  output logic [2*DW-1:0]   staged,
  output logic [DW-1:0]     ctrl_q
);
  localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(BASE + IDX_CTRL);
  localparam logic [REG_AW-1:0] A_PTR_H = REG_AW'(BASE + IDX_PTR_H);
  localparam logic [REG_AW-1:0] A_PTR_L = REG_AW'(BASE + IDX_PTR_L);
  localparam logic [REG_AW-1:0] A_DAT_H = REG_AW'(BASE + IDX_DAT_H);
  localparam logic [REG_AW-1:0] A_DAT_L = REG_AW'(BASE + IDX_DAT_L);
  localparam logic [DW-1:0]     LOW_KEEP = {{(DW-2){1'b1}}, 2'b00};
  localparam logic [2*DW-1:0]   STEP     = (2*DW)'(4);

  logic [2*DW-1:0] ptr_d, staged_d;
  logic [DW-1:0]   ctrl_d;

  always_comb begin
    ptr_d    = ptr;
    staged_d = staged;
    ctrl_d   = ctrl_q;
    if (advance) ptr_d = ptr + STEP;
    if (wr_en) begin
      if (wr_sel == A_PTR_H) ptr_d[2*DW-1:DW]    = wr_data;
      if (wr_sel == A_PTR_L) ptr_d[DW-1:0]       = wr_data & LOW_KEEP;
      if (wr_sel == A_DAT_H) staged_d[2*DW-1:DW] = wr_data;
      if (wr_sel == A_DAT_L) staged_d[DW-1:0]    = wr_data;
      if (wr_sel == A_CTRL)  ctrl_d              = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      staged <= '0;
      ctrl_q <= '0;
    end else begin
      ptr    <= ptr_d;
      staged <= staged_d;
      ctrl_q <= ctrl_d;
    end
  end

  // R3
  ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n) ptr[1:0] == 2'b00);
endmodule

// File: rtl/mbox_crc16.sv
module mbox_crc16
  import mbox_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic [15:0]       crc,
  output logic              busy
);
  localparam int NBYTES = WORD_W / 8;
  localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [15:0]       crc_d;
  logic              busy_d;

  always_comb begin
    crc_d  = crc;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy;
    if (clr) crc_d = '0;
    if (busy) begin
      crc_d = crc16_byte(crc, sh_q[WORD_W-1 -: 8]);
      sh_d  = sh_q << 8;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end else if (start) begin
      sh_d   = word;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc   <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      crc   <= crc_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

  // R6: an idle engine keeps its accumulator unless cleared
  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr) |=> (crc == $past(crc)));
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport
  import mbox_pkg::*;
#(
  parameter int REG_AW = 16,
  parameter int DW     = 16,
  parameter int BASE   = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_sel,
  input  logic [2*DW-1:0]   ptr,
  input  logic [2*DW-1:0]   staged,
  input  logic [DW-1:0]     ctrl_q,
  input  logic [15:0]       crc,
  input  logic              busy,
  output logic [DW-1:0]     rd_data
);
  localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(BASE + IDX_CTRL);
  localparam logic [REG_AW-1:0] A_CRC   = REG_AW'(BASE + IDX_CRC);
  localparam logic [REG_AW-1:0] A_PTR_H = REG_AW'(BASE + IDX_PTR_H);
  localparam logic [REG_AW-1:0] A_PTR_L = REG_AW'(BASE + IDX_PTR_L);
  localparam logic [REG_AW-1:0] A_DAT_H = REG_AW'(BASE + IDX_DAT_H);
  localparam logic [REG_AW-1:0] A_DAT_L = REG_AW'(BASE + IDX_DAT_L);

  logic [DW-1:0] rd_d, ctrl_view;

  always_comb begin
    ctrl_view           = ctrl_q;
    ctrl_view[BIT_BUSY] = busy;
    rd_d = rd_data;
    if (rd_en) begin
      case (rd_sel)
        A_CTRL:  rd_d = ctrl_view;
        A_CRC:   rd_d = DW'(crc);
        A_PTR_H: rd_d = ptr[2*DW-1:DW];
        A_PTR_L: rd_d = ptr[DW-1:0];
        A_DAT_H: rd_d = staged[2*DW-1:DW];
        A_DAT_L: rd_d = staged[DW-1:0];
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/mbox_crc_loader.sv
module mbox_crc_loader
  import mbox_pkg::*;
#(
  parameter int REG_AW = 16,
  parameter int DW     = 16,
  parameter int BASE   = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_we,
  output logic [2*DW-1:0]   mem_addr,
  output logic [2*DW-1:0]   mem_wdata
);
  localparam int WW     = 2 * DW;
  localparam int NBYTES = WW / 8;
  localparam int RUNW   = $clog2(NBYTES) + 2;
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(BASE + IDX_CTRL);

  logic [WW-1:0] ptr, staged;
  logic [DW-1:0] ctrl_q;
  logic [15:0]   crc;
  logic          busy;
  logic          ctrl_wr, exec_req, clr_req, commit, clr_ok;

  assign ctrl_wr  = reg_wr && (reg_sel == A_CTRL);
  assign exec_req = ctrl_wr && reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE];
  assign clr_req  = ctrl_wr && reg_wdata[BIT_CLR];
  assign commit   = exec_req && !busy;
  assign clr_ok   = clr_req && !busy;

  mbox_regfile #(.REG_AW(REG_AW), .DW(DW), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .advance(commit), .ptr(ptr), .staged(staged), .ctrl_q(ctrl_q)
  );

  mbox_crc16 #(.WORD_W(WW)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr_ok), .start(commit), .word(staged),
    .crc(crc), .busy(busy)
  );

  mbox_rdport #(.REG_AW(REG_AW), .DW(DW), .BASE(BASE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .rd_sel(reg_sel), .ptr(ptr),
    .staged(staged), .ctrl_q(ctrl_q), .crc(crc), .busy(busy), .rd_data(reg_rdata)
  );

  // commit stage: next state then register
  logic          we_d;
  logic [WW-1:0] addr_d, wdata_d;

  always_comb begin
    we_d    = commit;
    addr_d  = mem_addr;
    wdata_d = mem_wdata;
    if (commit) begin
      addr_d  = ptr;
      wdata_d = staged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= we_d;
      mem_addr  <= addr_d;
      mem_wdata <= wdata_d;
    end
  end

  // busy-run counter for the window check
  logic [RUNW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);
  // R4
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  // R3
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr == mem_addr + WW'(4)));
  // R7
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_ok |=> (crc == 16'h0000));
  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUNW'(NBYTES)));
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exec_req) |=> !mem_we);
endmodule

// File: tb/test_mbox_crc_loader.sv
module test_mbox_crc_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reg_sel;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;

  localparam logic [15:0] O_CTRL = 16'h0200, O_CRC = 16'h0201, O_PH = 16'h0202,
                          O_PL = 16'h0203, O_DH = 16'h0204, O_DL = 16'h0205;

  always #5 clk = ~clk;

  mbox_crc_loader i_mbox_crc_loader (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  logic [31:0] exp_ptr;
  logic [15:0] exp_crc;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int k = 3; k >= 0; k--) begin
      r = r ^ {w[k*8 +: 8], 8'h00};
      for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    reg_sel = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stage, commit, record expectation, wait out busy
  task automatic push_word(input logic [31:0] w);
    wr(O_DH, w[31:16]);
    wr(O_DL, w[15:0]);
    exp_q.push_back({exp_ptr, w});
    exp_crc = model_crc(exp_crc, w);
    exp_ptr = exp_ptr + 32'd4;
    wr(O_CTRL, 16'hC000);
    idle(4);
  endtask

  // scoreboard monitor (R4, R5, R8, R9, R10)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_we === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected memory write", mem_addr, 32'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check(mem_addr == e[63:32], "R5 write address", mem_addr, e[63:32]);
        check(mem_wdata == e[31:0], "R4 write data", mem_wdata, e[31:0]);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; reg_sel = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    exp_crc = 16'h0000;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(mem_we == 1'b0, "R1 mem_we low", 32'(mem_we), 32'h0);
    rd(O_CTRL, v); check(v == 16'h0000, "R1 control", 32'(v), 32'h0);
    rd(O_CRC, v);  check(v == 16'h0000, "R1 crc", 32'(v), 32'h0);
    rd(O_PL, v);   check(v == 16'h0000, "R1 pointer low", 32'(v), 32'h0);

    // R2 R3 pointer halves and alignment
    wr(O_PH, 16'h3FFE);
    wr(O_PL, 16'h0007);
    rd(O_PL, v); check(v == 16'h0004, "R3 low bits forced zero", 32'(v), 32'h4);
    rd(O_PH, v); check(v == 16'h3FFE, "R2 pointer high", 32'(v), 32'h3FFE);
    exp_ptr = 32'h3FFE_0004;

    // R4 R5 R6 block of words
    push_word(32'h1122_3344);
    push_word(32'hA5A5_0F0F);
    push_word(32'hDEAD_BEEF);
    rd(O_CRC, v); check(v == exp_crc, "R6 crc after block", 32'(v), 32'(exp_crc));
    rd(O_PL, v);  check(v == exp_ptr[15:0], "R5 pointer advanced", 32'(v), 32'(exp_ptr[15:0]));
    rd(O_DH, v);  check(v == 16'hDEAD, "R2 data high readback", 32'(v), 32'hDEAD);

    // R8 busy window: commands during it are dropped
    wr(O_DH, 16'h0102);
    wr(O_DL, 16'h0304);
    exp_q.push_back({exp_ptr, 32'h0102_0304});
    exp_crc = model_crc(exp_crc, 32'h0102_0304);
    exp_ptr = exp_ptr + 32'd4;
    wr(O_CTRL, 16'hC000);
    rd(O_CTRL, v); check(v[8] == 1'b1, "R8 busy set", 32'(v), 32'hC100);
    wr(O_CTRL, 16'hC000);
    wr(O_CTRL, 16'h1000);
    idle(3);
    rd(O_CRC, v);  check(v == exp_crc, "R8 clear during busy ignored", 32'(v), 32'(exp_crc));
    rd(O_CTRL, v); check(v == 16'h1000, "R8 busy cleared, control readback", 32'(v), 32'h1000);

    // R7 clear
    wr(O_CTRL, 16'h1000);
    exp_crc = 16'h0000;
    rd(O_CRC, v); check(v == 16'h0000, "R7 crc cleared", 32'(v), 32'h0);
    push_word(32'h3132_3334);
    rd(O_CRC, v); check(v == exp_crc, "R6 crc single word", 32'(v), 32'(exp_crc));

    // R7 clear together with commit
    wr(O_DH, 16'hCAFE);
    wr(O_DL, 16'hF00D);
    exp_q.push_back({exp_ptr, 32'hCAFE_F00D});
    exp_ptr = exp_ptr + 32'd4;
    exp_crc = model_crc(16'h0000, 32'hCAFE_F00D);
    wr(O_CTRL, 16'hD000);
    idle(4);
    rd(O_CRC, v); check(v == exp_crc, "R7 clear then commit", 32'(v), 32'(exp_crc));

    // R9 execute without write bit
    wr(O_CTRL, 16'h8000);
    idle(4);
    rd(O_CRC, v); check(v == exp_crc, "R9 crc unchanged", 32'(v), 32'(exp_crc));
    rd(O_PL, v);  check(v == exp_ptr[15:0], "R9 pointer unchanged", 32'(v), 32'(exp_ptr[15:0]));

    // R10 restage during busy
    wr(O_DH, 16'h0A0B);
    wr(O_DL, 16'h0C0D);
    exp_q.push_back({exp_ptr, 32'h0A0B_0C0D});
    exp_crc = model_crc(exp_crc, 32'h0A0B_0C0D);
    exp_ptr = exp_ptr + 32'd4;
    wr(O_CTRL, 16'hC000);
    wr(O_DH, 16'h5566);
    wr(O_DL, 16'h7788);
    idle(2);
    exp_q.push_back({exp_ptr, 32'h5566_7788});
    exp_crc = model_crc(exp_crc, 32'h5566_7788);
    exp_ptr = exp_ptr + 32'd4;
    wr(O_CTRL, 16'hC000);
    idle(4);
    rd(O_CRC, v); check(v == exp_crc, "R10 crc over both words", 32'(v), 32'(exp_crc));

    // R5 carry across halves
    wr(O_PH, 16'h0001);
    wr(O_PL, 16'hFFFE);
    exp_ptr = 32'h0001_FFFC;
    push_word(32'h0000_0001);
    push_word(32'hFFFF_FFFF);
    rd(O_PH, v); check(v == 16'h0002, "R5 carry into high half", 32'(v), 32'h2);
    rd(O_PL, v); check(v == 16'h0004, "R5 low half after carry", 32'(v), 32'h4);

    // R2 unmapped offsets
    rd(16'h0206, v); check(v == 16'h0000, "R2 unmapped above", 32'(v), 32'h0);
    rd(16'h0100, v); check(v == 16'h0000, "R2 unmapped below", 32'(v), 32'h0);

    idle(2);
    check(exp_q.size() == 0, "R4 all expected writes seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule